// File: doc/BRIEF.md
# SDRAM Command Interface Decoder

This block is the pin-level front end of a behavioural SDRAM model. On every rising clock edge it samples the control strobes (chip select, row strobe, column strobe, write enable), clock enable, bank select, address and byte-mask pins. It classifies the cycle as exactly one command and presents that command one cycle later as a registered code with a valid strobe. The bank, row, column, auto-precharge flag, precharge-all flag and mode op-code are broken out of the address pins according to the command. Fields that a command does not use are forced to zero.

The address pin A10 carries two meanings. On column commands it requests auto-precharge, and on precharge it selects all banks. Clock enable splits the refresh encoding into auto refresh and self-refresh entry. Both take their row from an internal 12-bit refresh counter that advances only on auto refresh. The byte-mask pins are pipelined into a write data enable and a read output enable. The write enable lines up with the command sampled on the same edge. The read output enable follows two clocks later.

The column width follows a data-width parameter of 4, 8 or 16. The number of mask lanes is one below 16 bits of data and one per byte at 16 bits.

Top module: `sdr_cmd_front`

## Requirements
- R1: While cs_n is high on a sampling edge, the next cycle shows cmd_vld low, cmd_code 0 (no-op) and every decoded field zero, whatever the other pins are.
- R2: With cs_n low and cke high, {ras_n,cas_n,we_n} decode to cmd_code as follows: 111→0 no-op, 011→1 activate, 101→2 read, 100→3 write, 110→4 burst stop, 010→5 precharge, 001→6 auto refresh, 000→8 mode load.
- R3: On activate, cmd_row equals addr[11:0] and cmd_bank equals ba.
- R4: On read or write, cmd_col equals the low COL_W address bits (COL_W is 10, 9 or 8 for DATA_W 4, 8 or 16), cmd_bank equals ba, and cmd_autopre equals addr[10].
- R5: On precharge with addr[10] low, cmd_bank equals ba and cmd_preall is 0. With addr[10] high, cmd_preall is 1 and cmd_bank is 0.
- R6: The refresh encoding with cke high is auto refresh (code 6), and with cke low it is self-refresh entry (code 7). Both report cmd_row equal to a 12-bit counter that starts at 0 after reset. The counter advances by one, wrapping 4095→0, only after auto refresh.
- R7: On mode load, cmd_opcode equals addr[11:0].
- R8: With cke low, every encoding other than refresh yields cmd_vld low and code 0, and leaves the refresh counter unchanged.
- R9: Every field that the current command does not define reads zero.
- R10: Decoded outputs appear in the cycle after the sampling edge. cmd_vld is high exactly when cmd_code is non-zero. After reset all outputs are zero.
- R11: wr_en equals the inverse of dqm sampled on the same edge as the command that it accompanies.
- R12: rd_oe equals the inverse of dqm sampled two edges before the edge that the decoded command comes from, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | BANK_W | Bank select |
| addr | input | ADDR_W | Multiplexed address / op-code |
| dqm | input | MASK_W | Byte mask, high blocks data |
| cmd_vld | output | 1 | High for one cycle per decoded command |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | BANK_W | Decoded bank |
| cmd_row | output | ADDR_W | Row for activate or refresh |
| cmd_col | output | COL_W | Column for read or write |
| cmd_autopre | output | 1 | Auto-precharge request |
| cmd_preall | output | 1 | Precharge targets all banks |
| cmd_opcode | output | ADDR_W | Mode register op-code |
| wr_en | output | MASK_W | Write data lane enable |
| rd_oe | output | MASK_W | Read data lane output enable |

## Verification
The embedded properties watch these rules on every cycle: chip-select-high silence, the clock-enable-low filter, precharge-all never carrying a bank, auto-precharge appearing only on column commands, the counter's step and hold rules, and both mask latencies. What the properties cannot show is the full decode table, the exact field values taken from each pin pattern, the column width of each data-width variant, and the counter's wrap and its freezing through self-refresh and ignored cycles. The bench covers these by sweeping every strobe and clock-enable combination under several address and mask patterns on a 4-bit and a 16-bit instance, and then running a long auto-refresh stream past the counter wrap.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_BST  = 4'd4,
        CMD_PRE  = 4'd5,
        CMD_AREF = 4'd6,
        CMD_SREF = 4'd7,
        CMD_LMR  = 4'd8
    } sdr_cmd_e;

    // Extra clocks of read-mask delay beyond the write path
    localparam int RD_MASK_EXTRA = 2;

    function automatic int col_bits(input int data_w);
        if (data_w >= 16)
            return 8;
        else if (data_w >= 8)
            return 9;
        else
            return 10;
    endfunction

    function automatic int mask_bits(input int data_w);
        if (data_w > 8)
            return data_w / 8;
        else
            return 1;
    endfunction

endpackage

// File: rtl/sdr_pin_classify.sv
module sdr_pin_classify
    import sdr_cmd_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    input  logic     cke,
    output sdr_cmd_e cmd
);

    sdr_cmd_e raw_cmd;

    always_comb begin
        raw_cmd = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b111:  raw_cmd = CMD_NOP;
                3'b011:  raw_cmd = CMD_ACT;
                3'b101:  raw_cmd = CMD_RD;
                3'b100:  raw_cmd = CMD_WR;
                3'b110:  raw_cmd = CMD_BST;
                3'b010:  raw_cmd = CMD_PRE;
                3'b001:  raw_cmd = CMD_AREF;
                3'b000:  raw_cmd = CMD_LMR;
                default: raw_cmd = CMD_NOP;
            endcase
        end
    end

    // Clock enable low keeps only the refresh encoding, turned into self-refresh entry
    always_comb begin
        if (cke)
            cmd = raw_cmd;
        else if (raw_cmd == CMD_AREF)
            cmd = CMD_SREF;
        else
            cmd = CMD_NOP;
    end

endmodule

// File: rtl/sdr_field_extract.sv
module sdr_field_extract
    import sdr_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int AP_BIT = 10
) (
    input  sdr_cmd_e            cmd,
    input  logic [BANK_W-1:0]   ba,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [ADDR_W-1:0]   ref_row,
    output logic [BANK_W-1:0]   bank,
    output logic [ADDR_W-1:0]   row,
    output logic [COL_W-1:0]    col,
    output logic                autopre,
    output logic                preall,
    output logic [ADDR_W-1:0]   opcode
);

    logic [COL_W-1:0] col_field;

    generate
        if (COL_W < ADDR_W) begin : g_col_narrow
            assign col_field = addr[COL_W-1:0];
        end else begin : g_col_full
            assign col_field = COL_W'(addr);
        end
    endgenerate

    always_comb begin
        bank    = '0;
        row     = '0;
        col     = '0;
        autopre = 1'b0;
        preall  = 1'b0;
        opcode  = '0;
        case (cmd)
            CMD_ACT: begin
                bank = ba;
                row  = addr;
            end
            CMD_RD, CMD_WR: begin
                bank    = ba;
                col     = col_field;
                autopre = addr[AP_BIT];
            end
            CMD_PRE: begin
                preall = addr[AP_BIT];
                bank   = addr[AP_BIT] ? '0 : ba;
            end
            CMD_AREF, CMD_SREF: begin
                row = ref_row;
            end
            CMD_LMR: begin
                opcode = addr;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sdr_refresh_ctr.sv
module sdr_refresh_ctr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (inc)
            ctr_d.cnt = ctr_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctr_q <= '0;
        else
            ctr_q <= ctr_d;
    end

    assign cnt = ctr_q.cnt;

    AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1)))); // R6

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt)); // R8

endmodule

// File: rtl/sdr_mask_pipe.sv
module sdr_mask_pipe
    import sdr_cmd_pkg::*;
#(
    parameter int MASK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MASK_W-1:0] dqm,
    output logic [MASK_W-1:0] wr_en,
    output logic [MASK_W-1:0] rd_oe
);

    localparam int RD_STAGES = RD_MASK_EXTRA + 1;

    typedef struct packed {
        logic [MASK_W-1:0]                wr_en;
        logic [RD_STAGES-1:0][MASK_W-1:0] rd_pipe;
    } mpipe_t;

    mpipe_t mp_d, mp_q;

    always_comb begin
        mp_d            = mp_q;
        mp_d.wr_en      = ~dqm;
        mp_d.rd_pipe[0] = ~dqm;
        for (int s = 1; s < RD_STAGES; s++)
            mp_d.rd_pipe[s] = mp_q.rd_pipe[s-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mp_q <= '0;
        else
            mp_q <= mp_d;
    end

    assign wr_en = mp_q.wr_en;
    assign rd_oe = mp_q.rd_pipe[RD_STAGES-1];

    AST_WR_MASK_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (dqm == '1) |=> (wr_en == '0)); // R11

    AST_WR_OPEN_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (dqm == '0) |=> (wr_en == '1)); // R11

    AST_RD_MASK_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (dqm == '1) |-> ##3 (rd_oe == '0)); // R12

endmodule

// File: rtl/sdr_cmd_front.sv
module sdr_cmd_front
    import sdr_cmd_pkg::*;
#(
    parameter  int DATA_W = 4,
    parameter  int ADDR_W = 12,
    parameter  int BANK_W = 2,
    parameter  int AP_BIT = 10,
    localparam int COL_W  = col_bits(DATA_W),
    localparam int MASK_W = mask_bits(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              cke,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [MASK_W-1:0] dqm,
    output logic              cmd_vld,
    output logic [3:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_autopre,
    output logic              cmd_preall,
    output logic [ADDR_W-1:0] cmd_opcode,
    output logic [MASK_W-1:0] wr_en,
    output logic [MASK_W-1:0] rd_oe
);

    typedef struct packed {
        logic              vld;
        sdr_cmd_e          code;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] row;
        logic [COL_W-1:0]  col;
        logic              autopre;
        logic              preall;
        logic [ADDR_W-1:0] opcode;
    } dec_t;

    dec_t dec_d, dec_q;

    sdr_cmd_e          cur_cmd;
    logic [ADDR_W-1:0] ref_row;
    logic [BANK_W-1:0] f_bank;
    logic [ADDR_W-1:0] f_row;
    logic [COL_W-1:0]  f_col;
    logic              f_autopre;
    logic              f_preall;
    logic [ADDR_W-1:0] f_opcode;
    logic              ref_inc;

    sdr_pin_classify u_classify (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cke   (cke),
        .cmd   (cur_cmd)
    );

    sdr_field_extract #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .AP_BIT (AP_BIT)
    ) u_fields (
        .cmd     (cur_cmd),
        .ba      (ba),
        .addr    (addr),
        .ref_row (ref_row),
        .bank    (f_bank),
        .row     (f_row),
        .col     (f_col),
        .autopre (f_autopre),
        .preall  (f_preall),
        .opcode  (f_opcode)
    );

    assign ref_inc = (cur_cmd == CMD_AREF);

    sdr_refresh_ctr #(
        .CNT_W (ADDR_W)
    ) u_refctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ref_inc),
        .cnt   (ref_row)
    );

    sdr_mask_pipe #(
        .MASK_W (MASK_W)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .dqm   (dqm),
        .wr_en (wr_en),
        .rd_oe (rd_oe)
    );

    always_comb begin
        dec_d         = '0;
        dec_d.vld     = (cur_cmd != CMD_NOP);
        dec_d.code    = cur_cmd;
        dec_d.bank    = f_bank;
        dec_d.row     = f_row;
        dec_d.col     = f_col;
        dec_d.autopre = f_autopre;
        dec_d.preall  = f_preall;
        dec_d.opcode  = f_opcode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            dec_q <= '0;
        else
            dec_q <= dec_d;
    end

    assign cmd_vld     = dec_q.vld;
    assign cmd_code    = dec_q.code;
    assign cmd_bank    = dec_q.bank;
    assign cmd_row     = dec_q.row;
    assign cmd_col     = dec_q.col;
    assign cmd_autopre = dec_q.autopre;
    assign cmd_preall  = dec_q.preall;
    assign cmd_opcode  = dec_q.opcode;

    AST_INHIBIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!cmd_vld && cmd_code == 4'd0)); // R1

    AST_CKE_LOW_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (!cmd_vld || cmd_code == 4'(CMD_SREF))); // R8

    AST_PREALL_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_preall |-> (cmd_code == 4'(CMD_PRE) && cmd_bank == '0)); // R5

    AST_AP_COLUMN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_autopre |-> (cmd_code == 4'(CMD_RD) || cmd_code == 4'(CMD_WR))); // R4

    AST_IDLE_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |-> (cmd_code == 4'd0 && cmd_row == '0 && cmd_col == '0
                      && cmd_bank == '0 && cmd_opcode == '0)); // R9

endmodule

// File: tb/sim_sdr_cmd_front.sv
`timescale 1ns/1ps
module sim_sdr_cmd_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic [1:0]  dqm = 2'b11;

    logic        v0, v1, ap0, pa0, ap1, pa1;
    logic [3:0]  c0, c1;
    logic [1:0]  b0, b1;
    logic [11:0] r0, r1, o0, o1;
    logic [9:0]  col0;
    logic [7:0]  col1;
    logic [0:0]  we0, oe0;
    logic [1:0]  we1, oe1;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdr_cmd_front #(.DATA_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .dqm(dqm[0:0]),
        .cmd_vld(v0), .cmd_code(c0), .cmd_bank(b0), .cmd_row(r0), .cmd_col(col0),
        .cmd_autopre(ap0), .cmd_preall(pa0), .cmd_opcode(o0),
        .wr_en(we0), .rd_oe(oe0)
    );

    sdr_cmd_front #(.DATA_W(16)) u1 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .dqm(dqm),
        .cmd_vld(v1), .cmd_code(c1), .cmd_bank(b1), .cmd_row(r1), .cmd_col(col1),
        .cmd_autopre(ap1), .cmd_preall(pa1), .cmd_opcode(o1),
        .wr_en(we1), .rd_oe(oe1)
    );

    // Bench-side model state
    logic [11:0] ref_model = '0;
    logic [1:0]  hist1 = 2'b11;
    logic [1:0]  hist2 = 2'b11;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic i_cs, input logic i_ras, input logic i_cas,
                        input logic i_we, input logic i_cke, input logic [1:0] i_ba,
                        input logic [11:0] i_a, input logic [1:0] i_dqm);
        int    e_code;
        logic  [1:0] e_bank;
        logic  [11:0] e_row, e_op;
        logic  [9:0] e_col;
        logic  e_ap, e_pa;
        logic  [1:0] e_wr, e_rd;
        string lab;
        cs_n = i_cs; ras_n = i_ras; cas_n = i_cas; we_n = i_we; cke = i_cke;
        ba = i_ba; addr = i_a; dqm = i_dqm;
        // expected command from the R2 table
        if (i_cs) e_code = 0;
        else begin
            case ({i_ras, i_cas, i_we})
                3'b011: e_code = 1;
                3'b101: e_code = 2;
                3'b100: e_code = 3;
                3'b110: e_code = 4;
                3'b010: e_code = 5;
                3'b001: e_code = 6;
                3'b000: e_code = 8;
                default: e_code = 0;
            endcase
        end
        if (!i_cke) e_code = (e_code == 6) ? 7 : 0;
        if (i_cs) lab = "R1";
        else if (!i_cke && e_code == 0) lab = "R8";
        else case (e_code)
            1: lab = "R3";
            2, 3: lab = "R4";
            5: lab = "R5";
            6, 7: lab = "R6";
            8: lab = "R7";
            default: lab = "R2";
        endcase
        e_bank = '0; e_row = '0; e_op = '0; e_col = '0; e_ap = 0; e_pa = 0;
        if (e_code == 1) begin e_bank = i_ba; e_row = i_a; end
        if (e_code == 2 || e_code == 3) begin e_bank = i_ba; e_col = i_a[9:0]; e_ap = i_a[10]; end
        if (e_code == 5) begin e_pa = i_a[10]; e_bank = i_a[10] ? 2'b00 : i_ba; end
        if (e_code == 6 || e_code == 7) e_row = ref_model;
        if (e_code == 8) e_op = i_a;
        e_wr = ~i_dqm;
        e_rd = ~hist2;
        @(posedge clk);
        hist2 = hist1;
        hist1 = i_dqm;
        @(negedge clk);
        chk({lab, " R2 code x4"}, 32'(c0), 32'(e_code));
        chk({lab, " R2 code x16"}, 32'(c1), 32'(e_code));
        chk({lab, " R10 valid"}, 32'(v0), 32'(e_code != 0));
        chk({lab, " R10 valid x16"}, 32'(v1), 32'(e_code != 0));
        chk({lab, " bank (R9 when unused)"}, 32'(b0), 32'(e_bank));
        chk({lab, " row (R9 when unused)"}, 32'(r0), 32'(e_row));
        chk({lab, " row x16"}, 32'(r1), 32'(e_row));
        chk({lab, " R4 col x4 (R9 when unused)"}, 32'(col0), 32'(e_col));
        chk({lab, " R4 col x16 (R9 when unused)"}, 32'(col1), 32'(e_col[7:0]));
        chk({lab, " autopre (R9 when unused)"}, 32'(ap0), 32'(e_ap));
        chk({lab, " preall (R9 when unused)"}, 32'(pa0), 32'(e_pa));
        chk({lab, " opcode (R9 when unused)"}, 32'(o0), 32'(e_op));
        chk("R11 wr_en x4", 32'(we0), 32'(e_wr[0]));
        chk("R11 wr_en x16", 32'(we1), 32'(e_wr));
        chk("R12 rd_oe x4", 32'(oe0), 32'(e_rd[0]));
        chk("R12 rd_oe x16", 32'(oe1), 32'(e_rd));
        if (e_code == 6) ref_model = ref_model + 12'd1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    logic [11:0] pats [4] = '{12'h000, 12'hFFF, 12'h3A5, 12'h5A5};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 reset vld", 32'(v0), 0);
        chk("R10 reset code", 32'(c0), 0);
        chk("R10 reset row", 32'(r0), 0);
        chk("R12 reset rd_oe", 32'(oe1), 0);
        chk("R11 reset wr_en", 32'(we1), 0);
        rst_n = 1'b1;
        // Sweep of every strobe and clock-enable combination
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 32; i++) begin
                logic [4:0] s;
                s = 5'(i);
                step(s[4], s[3], s[2], s[1], s[0], 2'(p + i), pats[p] ^ 12'(i * 3),
                     {s[0] ^ 1'(p), 1'((i + p) % 3 == 0)});
            end
        end
        // R5: precharge, single bank versus all banks
        step(0, 0, 1, 0, 1, 2'b10, 12'h000, 2'b00);
        step(0, 0, 1, 0, 1, 2'b11, 12'h400, 2'b00);
        // R6/R8: self refresh and ignored cycles hold the counter
        step(0, 0, 0, 1, 0, 2'b00, 12'h123, 2'b01);
        step(0, 0, 1, 1, 0, 2'b01, 12'h456, 2'b10);
        step(0, 0, 0, 1, 0, 2'b00, 12'h789, 2'b11);
        // R6: long auto refresh run across the counter wrap
        for (int k = 0; k < 4100; k++)
            step(0, 0, 0, 1, 1, 2'(k), 12'(k * 7), 2'(k));
        step(0, 0, 0, 1, 0, 2'b00, 12'h000, 2'b00);
        finish_run();
    end

    initial begin
        #(8 * 20000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=expired expected=complete");
        finish_run();
    end

endmodule